// File: doc/BRIEF.md
# Queue-Based Register Rename Table

This block maps architectural registers to physical register tags. Each architectural register owns a small circular queue of tags. The queue keeps the committed mapping and every speculative mapping made after it, and none of them is ever overwritten. A rename writes the new tag into the slot after the queue's tail and moves the tail onto it. A lookup returns the tag under the tail, which is the newest mapping. Commit moves the head forward, so the entry under each head pointer is the committed mapping. The block exports that set of entries as the committed map and stores no separate committed copy.

Misprediction recovery moves tail pointers only. A walk-back step retracts the tail of one architectural register, once for each squashed instruction. A bulk load replaces every tail pointer in one cycle, for example from a per-branch checkpoint of the `tails_out` vector. Slot 0 of queue *a* holds tag *a* after reset. `DEPTH` must be a power of two, so pointers wrap modulo `DEPTH`. One slot always holds the committed entry, so at most `DEPTH-1` speculative mappings can be outstanding for each register.

The rename port is valid/ready. A rename is taken on a clock edge where `ren_valid` and `ren_ready` are both high. `ren_ready` is combinational: it depends on `ren_arch` and on the recovery inputs. It is low when the target queue is full, and also while `walk_valid` or `load_valid` is high. The source must hold the request until it is accepted. Commit, walk-back and load are plain single-cycle strobes with no handshake.

Top module: `qrt_rename_table`

## Requirements
- R1: After reset, every tail pointer is 0, `commit_map` entry *a* is tag *a*, both lookups of register *a* return *a*, and `ren_ready` is 1.
- R2: An accepted rename of register *a* advances *a*'s tail by one (mod `DEPTH`). From the next cycle, lookups of *a* return the new tag.
- R3: Renaming never overwrites an older mapping. After walk-back steps, the earlier tags are returned again unchanged.
- R4: When `DEPTH-1` speculative mappings of a register are outstanding, `ren_ready` is 0 for that register. A request held there changes nothing, and other registers stay ready.
- R5: A commit of register *a* advances its head, and `commit_map` entry *a* becomes its oldest speculative tag. A commit with no speculative mapping outstanding has no effect.
- R6: A walk-back step of register *a* moves its tail back by one (mod `DEPTH`), so lookups return the previous mapping. A step with nothing outstanding is ignored.
- R7: A load replaces all tail pointers with `load_tails` (field *a* at bits [a*4 +: 4] for the defaults) in one cycle. A walk-back step in the same cycle is ignored.
- R8: `ren_ready` is 0 whenever `walk_valid` or `load_valid` is 1. No rename is taken in that cycle.
- R9: Head and tail pointers wrap modulo `DEPTH`. Renames, commits and walk-back steps that cross the wrap give correct lookups and tails.
- R10: The two lookup ports work independently in the same cycle on different registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request valid |
| ren_ready | output | 1 | Rename request can be taken |
| ren_arch | input | AW | Destination architectural register |
| ren_tag | input | TW | New physical tag |
| rd0_arch | input | AW | Lookup port 0 register |
| rd0_tag | output | TW | Lookup port 0 newest tag |
| rd1_arch | input | AW | Lookup port 1 register |
| rd1_tag | output | TW | Lookup port 1 newest tag |
| cmt_valid | input | 1 | Commit strobe |
| cmt_arch | input | AW | Register whose oldest speculative mapping commits |
| walk_valid | input | 1 | Walk-back strobe |
| walk_arch | input | AW | Register written by the squashed instruction |
| load_valid | input | 1 | Bulk tail-pointer load strobe |
| load_tails | input | NUM_ARCH*PW | Tail pointers to load, one field per register |
| tails_out | output | NUM_ARCH*PW | Current tail pointers, for checkpointing |
| commit_map | output | NUM_ARCH*TW | Committed tag of each register |

## Verification
The hardest state to reach is a queue whose pointers have crossed the wrap point. Walk-back steps must then step back across slot 0 while the head sits above the tail. The stimulus gets there in three stages. It fills one register's queue until the register stalls, then loads a tail value well short of full. It then commits that register up to the loaded tail, and renames enough times to wrap the tail past slot 0. After that, walk-back steps cross the wrap while lookups are checked at each stage.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  // selects how a pointer unit's tail moves in a cycle
  typedef enum logic [1:0] {
    TAIL_HOLD = 2'd0,
    TAIL_PUSH = 2'd1,
    TAIL_BACK = 2'd2,
    TAIL_LOAD = 2'd3
  } tail_move_e;
endpackage

// File: rtl/qrt_ptr_unit.sv
module qrt_ptr_unit
  import qrt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          commit,
  input  logic          walk,
  input  logic          load,
  input  logic [PW-1:0] load_ptr,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic          full
);
  logic [PW-1:0] count;
  logic          commit_ok;
  logic          walk_ok;
  tail_move_e    move;

  assign count     = tail - head;
  assign full      = (count == PW'(DEPTH - 1));
  assign commit_ok = commit && (count != '0);
  assign walk_ok   = walk && !load && (count != '0) &&
                     !(commit && (count == PW'(1)));

  always_comb begin
    if (load)         move = TAIL_LOAD;
    else if (walk_ok) move = TAIL_BACK;
    else if (push)    move = TAIL_PUSH;
    else              move = TAIL_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (commit_ok) head <= head + PW'(1);
      unique case (move)
        TAIL_LOAD: tail <= load_ptr;
        TAIL_BACK: tail <= tail - PW'(1);
        TAIL_PUSH: tail <= tail + PW'(1);
        default:   tail <= tail;
      endcase
    end
  end

  // R4: a push never lands on a full queue
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R2: an accepted push with no recovery moves the tail forward by one
  p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !load && !walk) |=> tail == $past(tail) + PW'(1));
  // R5: head moves only on a commit
  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(head));
  // R6: a walk on an empty queue leaves the tail alone
  p_walk_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk && !load && !push && tail == head) |=> $stable(tail));
  // R7: a load sets the tail to the loaded value
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tail == $past(load_ptr));
endmodule

// File: rtl/qrt_tag_store.sv
module qrt_tag_store #(
  parameter int NUM_ARCH = 8,
  parameter int DEPTH    = 16,
  parameter int TW       = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int AW = $clog2(NUM_ARCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [AW-1:0]          w_arch,
  input  logic [PW-1:0]          w_slot,
  input  logic [TW-1:0]          w_tag,
  input  logic [NUM_ARCH*PW-1:0] heads,
  input  logic [NUM_ARCH*PW-1:0] tails,
  output logic [NUM_ARCH*TW-1:0] head_tags,
  output logic [NUM_ARCH*TW-1:0] tail_tags
);
  logic [TW-1:0] mem [NUM_ARCH][DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++)
        for (int s = 0; s < DEPTH; s++)
          mem[a][s] <= (s == 0) ? TW'(a) : '0;
    end else if (we) begin
      mem[w_arch][w_slot] <= w_tag;
    end
  end

  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_rd
    assign head_tags[a*TW +: TW] = mem[a][heads[a*PW +: PW]];
    assign tail_tags[a*TW +: TW] = mem[a][tails[a*PW +: PW]];
  end
endmodule

// File: rtl/qrt_rename_table.sv
module qrt_rename_table #(
  parameter int NUM_ARCH = 8,
  parameter int DEPTH    = 16,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(DEPTH),
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ren_valid,
  output logic                   ren_ready,
  input  logic [AW-1:0]          ren_arch,
  input  logic [TW-1:0]          ren_tag,
  input  logic [AW-1:0]          rd0_arch,
  output logic [TW-1:0]          rd0_tag,
  input  logic [AW-1:0]          rd1_arch,
  output logic [TW-1:0]          rd1_tag,
  input  logic                   cmt_valid,
  input  logic [AW-1:0]          cmt_arch,
  input  logic                   walk_valid,
  input  logic [AW-1:0]          walk_arch,
  input  logic                   load_valid,
  input  logic [NUM_ARCH*PW-1:0] load_tails,
  output logic [NUM_ARCH*PW-1:0] tails_out,
  output logic [NUM_ARCH*TW-1:0] commit_map
);
  logic [NUM_ARCH*PW-1:0] heads;
  logic [NUM_ARCH*TW-1:0] newest;
  logic [NUM_ARCH-1:0]    full_v;
  logic                   ren_fire;
  logic [PW-1:0]          cur_tail;

  assign ren_ready = !walk_valid && !load_valid && !full_v[ren_arch];
  assign ren_fire  = ren_valid && ren_ready;
  assign cur_tail  = tails_out[ren_arch*PW +: PW];

  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_q
    qrt_ptr_unit #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ren_fire && (ren_arch == AW'(a))),
      .commit   (cmt_valid && (cmt_arch == AW'(a))),
      .walk     (walk_valid && (walk_arch == AW'(a))),
      .load     (load_valid),
      .load_ptr (load_tails[a*PW +: PW]),
      .head     (heads[a*PW +: PW]),
      .tail     (tails_out[a*PW +: PW]),
      .full     (full_v[a])
    );
  end

  qrt_tag_store #(.NUM_ARCH(NUM_ARCH), .DEPTH(DEPTH), .TW(TW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ren_fire),
    .w_arch    (ren_arch),
    .w_slot    (cur_tail + PW'(1)),
    .w_tag     (ren_tag),
    .heads     (heads),
    .tails     (tails_out),
    .head_tags (commit_map),
    .tail_tags (newest)
  );

  assign rd0_tag = newest[rd0_arch*TW +: TW];
  assign rd1_tag = newest[rd1_arch*TW +: TW];

  // R8: recovery activity blocks the rename port
  p_ready_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid || load_valid) |-> !ren_ready);
  // R2: a plain rename is visible at the lookup of the same register next cycle
  p_rename_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && !cmt_valid && rd0_arch == ren_arch) |=>
      (rd0_arch != $past(ren_arch)) || (rd0_tag == $past(ren_tag)));
endmodule

// File: tb/tb_qrt_rename_table.sv
module tb_qrt_rename_table;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int AW = 3;
  localparam int PW = 4;
  localparam int TW = 6;
  localparam int NV = 10;
  localparam logic [1:0] OP_NOP = 2'd0, OP_REN = 2'd1, OP_CMT = 2'd2, OP_WALK = 2'd3;

  // {op, arch, tag, expected lookup, expected committed tag, expected tail}
  localparam logic [26:0] VEC [NV] = '{
    {OP_REN,  3'd3, 6'd40, 6'd40, 6'd3,  4'd1},
    {OP_REN,  3'd3, 6'd41, 6'd41, 6'd3,  4'd2},
    {OP_REN,  3'd3, 6'd42, 6'd42, 6'd3,  4'd3},
    {OP_WALK, 3'd3, 6'd0,  6'd41, 6'd3,  4'd2},
    {OP_CMT,  3'd3, 6'd0,  6'd41, 6'd40, 4'd2},
    {OP_CMT,  3'd3, 6'd0,  6'd41, 6'd41, 4'd2},
    {OP_CMT,  3'd3, 6'd0,  6'd41, 6'd41, 4'd2},
    {OP_WALK, 3'd3, 6'd0,  6'd41, 6'd41, 4'd2},
    {OP_REN,  3'd5, 6'd50, 6'd50, 6'd5,  4'd1},
    {OP_REN,  3'd3, 6'd43, 6'd43, 6'd41, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, cmt_valid = 1'b0, walk_valid = 1'b0, load_valid = 1'b0;
  logic [AW-1:0] ren_arch = '0, rd0_arch = '0, rd1_arch = '0, cmt_arch = '0, walk_arch = '0;
  logic [TW-1:0] ren_tag = '0;
  logic [NA*PW-1:0] load_tails = '0;
  logic ren_ready;
  logic [TW-1:0] rd0_tag, rd1_tag;
  logic [NA*PW-1:0] tails_out;
  logic [NA*TW-1:0] commit_map;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrt_rename_table dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_arch(ren_arch), .ren_tag(ren_tag),
    .rd0_arch(rd0_arch), .rd0_tag(rd0_tag), .rd1_arch(rd1_arch), .rd1_tag(rd1_tag),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch),
    .walk_valid(walk_valid), .walk_arch(walk_arch),
    .load_valid(load_valid), .load_tails(load_tails),
    .tails_out(tails_out), .commit_map(commit_map)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one operation at a falling edge, let one rising edge pass, then release
  task automatic op(input logic [1:0] kind, input logic [AW-1:0] a, input logic [TW-1:0] t);
    @(negedge clk);
    ren_valid  = (kind == OP_REN);
    cmt_valid  = (kind == OP_CMT);
    walk_valid = (kind == OP_WALK);
    ren_arch = a; cmt_arch = a; walk_arch = a; ren_tag = t;
    @(posedge clk);
    #(CLK_PERIOD/4);
    ren_valid = 1'b0; cmt_valid = 1'b0; walk_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NA*PW-1:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    for (int a = 0; a < NA; a++) begin
      rd0_arch = AW'(a); #1;
      chk("R1 lookup", rd0_tag, a);
      chk("R1 commit_map", commit_map[a*TW +: TW], a);
      chk("R1 tail", tails_out[a*PW +: PW], 0);
    end
    chk("R1 ready", ren_ready, 1);

    // table walk: R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [1:0] k; logic [AW-1:0] a; logic [TW-1:0] t, e_rd, e_cm; logic [PW-1:0] e_tl;
      {k, a, t, e_rd, e_cm, e_tl} = VEC[i];
      op(k, a, t);
      rd0_arch = a; #1;
      chk("R2/R3/R6 table lookup", rd0_tag, e_rd);
      chk("R5 table commit_map", commit_map[a*TW +: TW], e_cm);
      chk("R2/R6 table tail", tails_out[a*PW +: PW], e_tl);
    end

    // R4: fill register 1 with tags 21..35
    for (int k = 1; k <= 15; k++) op(OP_REN, 3'd1, TW'(20 + k));
    ren_arch = 3'd1; #1;
    chk("R4 full not ready", ren_ready, 0);
    ren_arch = 3'd2; #1;
    chk("R4 other ready", ren_ready, 1);
    op(OP_REN, 3'd1, 6'd63);
    rd0_arch = 3'd1; #1;
    chk("R4 held request ignored", rd0_tag, 35);
    chk("R4 tail unchanged", tails_out[1*PW +: PW], 15);

    // R8: walk blocks renames
    @(negedge clk);
    ren_valid = 1'b1; ren_arch = 3'd2; ren_tag = 6'd60;
    walk_valid = 1'b1; walk_arch = 3'd0;
    #1;
    chk("R8 ready low on walk", ren_ready, 0);
    @(posedge clk); #(CLK_PERIOD/4);
    ren_valid = 1'b0; walk_valid = 1'b0;
    rd0_arch = 3'd2; #1;
    chk("R8 rename not taken", rd0_tag, 2);

    // R7: load all tails; arch1 -> 5, with a walk on arch1 the same cycle
    snap = tails_out;
    snap[1*PW +: PW] = 4'd5;
    @(negedge clk);
    load_valid = 1'b1; load_tails = snap;
    walk_valid = 1'b1; walk_arch = 3'd1;
    ren_arch = 3'd2; #1;
    chk("R8 ready low on load", ren_ready, 0);
    @(posedge clk); #(CLK_PERIOD/4);
    load_valid = 1'b0; walk_valid = 1'b0;
    #1;
    chk("R7 tails loaded", int'(tails_out == snap), 1);
    rd0_arch = 3'd1; #1;
    chk("R7 lookup after load", rd0_tag, 25);

    // R9: commit 5, then wrap the tail with 12 renames
    for (int k = 0; k < 5; k++) op(OP_CMT, 3'd1, '0);
    #1;
    chk("R9 commit_map after commits", commit_map[1*TW +: TW], 25);
    for (int k = 0; k < 12; k++) op(OP_REN, 3'd1, TW'(40 + k));
    rd0_arch = 3'd1; #1;
    chk("R9 wrapped tail", tails_out[1*PW +: PW], 1);
    chk("R9 wrapped lookup", rd0_tag, 51);
    op(OP_WALK, 3'd1, '0);
    op(OP_WALK, 3'd1, '0);
    rd0_arch = 3'd1; rd1_arch = 3'd3; #1;
    chk("R9 walk across wrap tail", tails_out[1*PW +: PW], 15);
    chk("R9 walk across wrap lookup", rd0_tag, 49);
    chk("R10 second port", rd1_tag, 43);
    chk("R3 older tag kept", rd0_tag, 49);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule